// File: doc/BRIEF.md
# Host-to-Frame-Buffer Rectangle Upload Engine

This block moves a rectangle of 16-bit pixels from a host command FIFO into an external frame buffer. A header arrives as two 32-bit words in a single cycle. The first word gives the destination corner and the second gives the rectangle size. From the size the engine works out how many 32-bit data words belong to the upload. It then pulls exactly that many words from the FIFO. It plans each burst as the smaller of the words still owed and the words the FIFO holds at that moment.

Every data word carries two pixels. The engine writes them one per cycle in raster order through a simple write port, and the frame-buffer coordinates wrap at the frame edges. Two mask controls act on each write. One suppresses a write whose target pixel already has its top bit set. The other forces the top bit of every written pixel.

An abort input ends an upload early, always at a whole-word boundary. The engine then reports the position it reached as a count of complete rows plus the pixels written in the last, partial row.

Top module: `hfb_upload`

## Requirements
- R1: The destination X is coordinate bits 9:0 and the destination Y is coordinate bits 24:16. Width is size bits 9:0 and height is size bits 24:16. A width field of 0 means 1024 and a height field of 0 means 512. All other header bits are ignored.
- R2: An accepted upload pops exactly ceil(width*height/2) words from the FIFO. It then pulses `done` for one cycle and drops `busy`.
- R3: `fifo_pop` is asserted only when `fifo_count` is nonzero. The engine never pops a word beyond the upload's own word count.
- R4: Pixels go out in raster order: columns first, then rows. Within each data word, bits 15:0 are written before bits 31:16.
- R5: The write address is (X+column) mod 1024 and (Y+row) mod 512.
- R6: When width*height is odd, the upper halfword of the final data word is discarded without a write.
- R7: A size word of 0xFFFFFFFF is ignored. No upload starts, nothing is popped and nothing is written.
- R8: When `chk_mask` is high and `fb_msb` reports bit 15 of the target pixel set, that pixel is not written. The raster position still advances.
- R9: When `set_mask` is high, bit 15 of every written pixel is 1.
- R10: An abort takes effect at the next word boundary. The engine then pulses `aborted` for one cycle, pops no further words and drops `busy`. `abort_rows` and `abort_cols` give floor(2*W/width) and (2*W) mod width, where W is the number of words consumed.
- R11: A header presented while `busy` is high has no effect on the upload in progress and starts nothing afterwards.
- R12: After reset `busy`, `px_we`, `fifo_pop`, `done` and `aborted` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Header present this cycle |
| cmd_coord | input | 32 | Destination corner word |
| cmd_size | input | 32 | Rectangle size word |
| fifo_count | input | 6 | Words currently held in the host FIFO |
| fifo_data | input | 32 | Head word of the host FIFO |
| fifo_pop | output | 1 | Consume the head word |
| abort_req | input | 1 | Request an early end of the upload |
| chk_mask | input | 1 | Skip writes onto pixels whose bit 15 is set |
| set_mask | input | 1 | Force bit 15 on written pixels |
| fb_msb | input | 1 | Bit 15 of the frame-buffer pixel at `px_x`,`px_y` |
| px_we | output | 1 | Pixel write strobe |
| px_x | output | 10 | Pixel write column |
| px_y | output | 9 | Pixel write row |
| px_data | output | 16 | Pixel write data |
| busy | output | 1 | Upload in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| aborted | output | 1 | One-cycle pulse on early end |
| abort_rows | output | 9 | Complete rows reached at the end of an upload |
| abort_cols | output | 10 | Pixels reached in the last partial row |

## Verification
An error in the remaining-word count shows up at the ports within one word as a pop count that is too high or too low. It can also show as a missing or early `done`, or as words left over in the FIFO when the upload finishes. An error in the raster position counters shows on the very next pixel: that pixel appears at the wrong coordinate or out of order against the scoreboard. A stale halfword latch shows as a wrong high pixel in the cycle right after its pop. An error in the abort path shows as pops continuing after the request, or as row and column figures that disagree with twice the number of words consumed.

// File: rtl/hfb_pkg.sv
package hfb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PLAN,
    ST_LO,
    ST_HI
  } hfb_state_e;

  // A zero-sized field selects the whole frame dimension.
  function automatic int unsigned dim_or_full(int unsigned raw, int unsigned full);
    return (raw == 0) ? full : raw;
  endfunction

  // Two pixels per word, rounded up.
  function automatic int unsigned word_count(int unsigned w, int unsigned h);
    return (w * h + 1) / 2;
  endfunction

  // Words taken by one burst.
  function automatic int unsigned burst_take(int unsigned rem, int unsigned avail);
    return (rem < avail) ? rem : avail;
  endfunction

  // Column after one pixel step; wraps when the row is full.
  function automatic int unsigned next_col(int unsigned col, int unsigned wid);
    return (col + 1 == wid) ? 0 : col + 1;
  endfunction

endpackage

// File: rtl/hfb_hdr_decode.sv
module hfb_hdr_decode #(
  parameter int XW   = 10,
  parameter int YW   = 9,
  parameter int YLSB = 16,
  parameter int NW   = XW + YW
) (
  input  logic [31:0]   coord,
  input  logic [31:0]   size,
  output logic [XW-1:0] dst_x,
  output logic [YW-1:0] dst_y,
  output logic [XW:0]   wid,
  output logic [YW:0]   hgt,
  output logic [NW-1:0] words,
  output logic          odd,
  output logic          skip_hdr
);
  import hfb_pkg::*;

  logic unused_coord;
  assign unused_coord = ^{coord[31:YLSB+YW], coord[YLSB-1:XW]};

  assign dst_x = coord[XW-1:0];
  assign dst_y = coord[YLSB +: YW];

  assign wid = (XW+1)'(dim_or_full(32'(size[XW-1:0]), 32'd1 << XW));
  assign hgt = (YW+1)'(dim_or_full(32'(size[YLSB +: YW]), 32'd1 << YW));

  assign words    = NW'(word_count(32'(wid), 32'(hgt)));
  assign odd      = wid[0] & hgt[0];
  assign skip_hdr = &size;

endmodule

// File: rtl/hfb_burst_ctrl.sv
module hfb_burst_ctrl #(
  parameter int NW = 19,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          skip_hdr,
  input  logic [NW-1:0] words,
  input  logic          odd,
  input  logic [CW-1:0] fifo_count,
  input  logic          abort_req,
  output logic          accept,
  output logic          busy,
  output logic          fifo_pop,
  output logic          slot_lo,
  output logic          slot_hi,
  output logic          done,
  output logic          aborted
);
  import hfb_pkg::*;

  hfb_state_e    st;
  logic [NW-1:0] rem_q;
  logic [NW-1:0] burst_q;
  logic          odd_q;
  logic          abort_q;
  logic          done_q;
  logic          abort_done_q;

  // Named events for the checks below
  logic ev_last_word;
  logic ev_abort_any;
  logic ev_plan_go;
  logic ev_stop;

  assign ev_abort_any = abort_req | abort_q;
  assign ev_last_word = (st == ST_HI) && (rem_q == '0);
  assign ev_plan_go   = (st == ST_PLAN) && !ev_abort_any && (fifo_count != '0);
  assign ev_stop      = ((st == ST_PLAN) && ev_abort_any) ||
                        ((st == ST_HI) && (rem_q != '0) && ev_abort_any);

  assign accept   = (st == ST_IDLE) && cmd_valid && !skip_hdr;
  assign busy     = (st != ST_IDLE);
  assign fifo_pop = (st == ST_LO);
  assign slot_lo  = (st == ST_LO);
  assign slot_hi  = (st == ST_HI) && !(ev_last_word && odd_q);
  assign done     = done_q;
  assign aborted  = abort_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      rem_q        <= '0;
      burst_q      <= '0;
      odd_q        <= 1'b0;
      abort_q      <= 1'b0;
      done_q       <= 1'b0;
      abort_done_q <= 1'b0;
    end else begin
      done_q       <= 1'b0;
      abort_done_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            rem_q   <= words;
            odd_q   <= odd;
            abort_q <= 1'b0;
            st      <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          if (ev_stop) begin
            abort_done_q <= 1'b1;
            st           <= ST_IDLE;
          end else if (ev_plan_go) begin
            burst_q <= NW'(burst_take(32'(rem_q), 32'(fifo_count)));
            st      <= ST_LO;
          end
        end
        ST_LO: begin
          rem_q   <= rem_q - 1'b1;
          burst_q <= burst_q - 1'b1;
          abort_q <= abort_q | abort_req;
          st      <= ST_HI;
        end
        default: begin
          if (ev_last_word) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else if (ev_stop) begin
            abort_done_q <= 1'b1;
            st           <= ST_IDLE;
          end else if (burst_q != '0) begin
            st <= ST_LO;
          end else begin
            st <= ST_PLAN;
          end
        end
      endcase
    end
  end

  // R3: a pop always finds a word in the FIFO
  a_r3_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_count != '0));

  // R3: a burst never claims more words than the upload still owes
  a_r3_burst_in_budget: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LO) |-> ((burst_q != '0) && (burst_q <= rem_q)));

  // R4: the low halfword cycle is always followed by the high halfword cycle
  a_r4_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LO) |=> (st == ST_HI));

  // R7: an all-ones size word leaves the engine idle
  a_r7_skip_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && cmd_valid && skip_hdr) |=> (st == ST_IDLE));

  // R10: completion and abort never coincide, and an abort ends the upload
  a_r10_single_end: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && aborted));
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> !busy);

endmodule

// File: rtl/hfb_pix_port.sv
module hfb_pix_port #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [XW-1:0] base_x,
  input  logic [YW-1:0] base_y,
  input  logic [XW:0]   wid,
  input  logic [31:0]   fifo_data,
  input  logic          slot_lo,
  input  logic          slot_hi,
  input  logic          chk_mask,
  input  logic          set_mask,
  input  logic          fb_msb,
  output logic          px_we,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic [15:0]   px_data,
  output logic [XW-1:0] pos_col,
  output logic [YW-1:0] pos_row
);
  import hfb_pkg::*;

  logic [XW-1:0] bx_q;
  logic [YW-1:0] by_q;
  logic [XW:0]   w_q;
  logic [15:0]   hi_q;
  logic [XW-1:0] col_q;
  logic [YW-1:0] row_q;

  logic        ev_slot;
  logic        ev_blocked;
  logic        ev_row_end;
  logic [15:0] pix_raw;

  assign ev_slot    = slot_lo | slot_hi;
  assign ev_blocked = ev_slot & chk_mask & fb_msb;
  assign ev_row_end = ev_slot && (next_col(32'(col_q), 32'(w_q)) == 0);
  assign pix_raw    = slot_lo ? fifo_data[15:0] : hi_q;

  // Additions truncate to the address width, which gives the frame wrap.
  assign px_x    = bx_q + col_q;
  assign px_y    = by_q + row_q;
  assign px_we   = ev_slot & ~ev_blocked;
  assign px_data = {pix_raw[15] | set_mask, pix_raw[14:0]};
  assign pos_col = col_q;
  assign pos_row = row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_q  <= '0;
      by_q  <= '0;
      w_q   <= '0;
      hi_q  <= '0;
      col_q <= '0;
      row_q <= '0;
    end else begin
      if (accept) begin
        bx_q  <= base_x;
        by_q  <= base_y;
        w_q   <= wid;
        col_q <= '0;
        row_q <= '0;
      end else if (ev_slot) begin
        col_q <= XW'(next_col(32'(col_q), 32'(w_q)));
        if (ev_row_end) row_q <= row_q + 1'b1;
      end
      if (slot_lo) hi_q <= fifo_data[31:16];
    end
  end

  // R8: a protected target pixel is never written
  a_r8_blocked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_slot && chk_mask && fb_msb) |-> !px_we);

  // R9: forced mask bit appears on every written pixel
  a_r9_mask_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (px_we && set_mask) |-> px_data[15]);

  // R5: the column counter stays inside the rectangle
  a_r5_col_in_rect: assert property (@(posedge clk) disable iff (!rst_n)
    (w_q != '0) |-> ({1'b0, col_q} < w_q));

  // R4: a high-half pixel only follows a low-half pixel
  a_r4_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
    slot_hi |-> $past(slot_lo));

endmodule

// File: rtl/hfb_upload.sv
module hfb_upload #(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [31:0]   cmd_coord,
  input  logic [31:0]   cmd_size,
  input  logic [CW-1:0] fifo_count,
  input  logic [31:0]   fifo_data,
  output logic          fifo_pop,
  input  logic          abort_req,
  input  logic          chk_mask,
  input  logic          set_mask,
  input  logic          fb_msb,
  output logic          px_we,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic [15:0]   px_data,
  output logic          busy,
  output logic          done,
  output logic          aborted,
  output logic [YW-1:0] abort_rows,
  output logic [XW-1:0] abort_cols
);
  localparam int NW = XW + YW;

  logic [XW-1:0] dst_x;
  logic [YW-1:0] dst_y;
  logic [XW:0]   wid;
  logic [YW:0]   hgt;
  logic [NW-1:0] words;
  logic          odd;
  logic          skip_hdr;
  logic          accept;
  logic          slot_lo;
  logic          slot_hi;

  hfb_hdr_decode #(.XW(XW), .YW(YW), .YLSB(16), .NW(NW)) u_dec (
    .coord    (cmd_coord),
    .size     (cmd_size),
    .dst_x    (dst_x),
    .dst_y    (dst_y),
    .wid      (wid),
    .hgt      (hgt),
    .words    (words),
    .odd      (odd),
    .skip_hdr (skip_hdr)
  );

  hfb_burst_ctrl #(.NW(NW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .skip_hdr   (skip_hdr),
    .words      (words),
    .odd        (odd),
    .fifo_count (fifo_count),
    .abort_req  (abort_req),
    .accept     (accept),
    .busy       (busy),
    .fifo_pop   (fifo_pop),
    .slot_lo    (slot_lo),
    .slot_hi    (slot_hi),
    .done       (done),
    .aborted    (aborted)
  );

  hfb_pix_port #(.XW(XW), .YW(YW)) u_pix (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .base_x    (dst_x),
    .base_y    (dst_y),
    .wid       (wid),
    .fifo_data (fifo_data),
    .slot_lo   (slot_lo),
    .slot_hi   (slot_hi),
    .chk_mask  (chk_mask),
    .set_mask  (set_mask),
    .fb_msb    (fb_msb),
    .px_we     (px_we),
    .px_x      (px_x),
    .px_y      (px_y),
    .px_data   (px_data),
    .pos_col   (abort_cols),
    .pos_row   (abort_rows)
  );

  // R11: a header seen mid-upload neither ends it nor restarts it
  a_r11_hdr_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !done && !aborted) |=> (busy || done || aborted));

  // R12: no write or pop happens outside an upload
  a_r12_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!px_we && !fifo_pop));

endmodule

// File: tb/tb_hfb_upload.sv
module tb_hfb_upload;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cmd_valid;
  logic [31:0] cmd_coord;
  logic [31:0] cmd_size;
  logic [5:0]  fifo_count;
  logic [31:0] fifo_data;
  logic        fifo_pop;
  logic        abort_req;
  logic        chk_mask;
  logic        set_mask;
  logic        fb_msb;
  logic        px_we;
  logic [9:0]  px_x;
  logic [8:0]  px_y;
  logic [15:0] px_data;
  logic        busy;
  logic        done;
  logic        aborted;
  logic [8:0]  abort_rows;
  logic [9:0]  abort_cols;

  hfb_upload dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_coord(cmd_coord),
    .cmd_size(cmd_size), .fifo_count(fifo_count), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .abort_req(abort_req), .chk_mask(chk_mask),
    .set_mask(set_mask), .fb_msb(fb_msb), .px_we(px_we), .px_x(px_x),
    .px_y(px_y), .px_data(px_data), .busy(busy), .done(done),
    .aborted(aborted), .abort_rows(abort_rows), .abort_cols(abort_cols)
  );

  logic [31:0] fq[$];
  logic [34:0] expq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    n_pops = 0;
  int    n_done = 0;
  int    n_abort = 0;
  int    cyc = 0;
  bit    pop_pend = 0;
  bit    pat_en = 0;
  logic [8:0] last_rows;
  logic [9:0] last_cols;
  string cur_req = "R12";

  // Protected-pixel pattern of the model frame buffer
  function automatic bit msb_at(int x, int y);
    return ((x + y) % 3) == 0;
  endfunction
  assign fb_msb = pat_en && msb_at(int'(px_x), int'(px_y));

  function automatic logic [31:0] wd(int seed, int i);
    logic [15:0] lo;
    lo = 16'(seed * 4099 + i * 37);
    return {~lo, lo};
  endfunction

  function automatic logic [31:0] mk(int lo, int hi);
    return (32'h55 << 25) | (32'(hi) << 16) | (32'h2A << 10) | 32'(lo);
  endfunction

  task automatic refresh();
    fifo_count = (fq.size() > 63) ? 6'd63 : 6'(fq.size());
    fifo_data  = (fq.size() != 0) ? fq[0] : 32'h0;
  endtask

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares pixel writes with the scoreboard and models the FIFO
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (px_we) begin
        if (expq.size() == 0) check(cur_req, "unexpected pixel write", {px_x, px_y, px_data}, -1);
        else check(cur_req, "pixel x/y/data", {px_x, px_y, px_data}, expq.pop_front());
      end
      if (pop_pend) begin
        if (fq.size() != 0) void'(fq.pop_front());
        pop_pend = 0;
      end
      if (fifo_pop) begin
        pop_pend = 1;
        n_pops++;
      end
      if (done) n_done++;
      if (aborted) begin
        n_abort++;
        last_rows = abort_rows;
        last_cols = abort_cols;
      end
      refresh();
    end
  end

  task automatic send_hdr(logic [31:0] c, logic [31:0] s);
    @(negedge clk);
    cmd_valid = 1; cmd_coord = c; cmd_size = s;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic push_words(int seed, int first, int n);
    for (int i = first; i < first + n; i++) fq.push_back(wd(seed, i));
    refresh();
  endtask

  // Driver side of the scoreboard: expected pixel stream
  task automatic exp_push(int x, int y, int w, int seed, int npix, bit sm, bit blk);
    for (int i = 0; i < npix; i++) begin
      logic [31:0] word;
      logic [15:0] pix;
      int ax, ay;
      word = wd(seed, i / 2);
      pix  = (i % 2) ? word[31:16] : word[15:0];
      ax = (x + i % w) % 1024;
      ay = (y + i / w) % 512;
      if (sm) pix[15] = 1'b1;
      if (!(blk && msb_at(ax, ay))) expq.push_back({10'(ax), 9'(ay), pix});
    end
  endtask

  task automatic wait_end(int lim);
    int e0, k;
    e0 = n_done + n_abort;
    k = 0;
    while ((n_done + n_abort) == e0 && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic do_rect(string req, int x, int y, int wraw, int hraw, int seed,
                         bit sm, bit cm, bit pe, int extra);
    int w, h, nw, p0, d0;
    w  = (wraw == 0) ? 1024 : wraw;
    h  = (hraw == 0) ? 512 : hraw;
    nw = (w * h + 1) / 2;
    cur_req = req;
    set_mask = sm; chk_mask = cm; pat_en = pe;
    push_words(seed, 0, nw + extra);
    exp_push(x, y, w, seed, w * h, sm, cm && pe);
    p0 = n_pops; d0 = n_done;
    send_hdr(mk(x, y), mk(wraw, hraw));
    wait_end(6000);
    check(req, "done pulses", n_done - d0, 1);
    check(req, "words popped", n_pops - p0, nw);
    check(req, "expected pixels not seen", expq.size(), 0);
    check(req, "words left in FIFO", fq.size(), extra);
    fq.delete(); expq.delete(); refresh();
    set_mask = 0; chk_mask = 0; pat_en = 0;
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_coord = 0; cmd_size = 0;
    abort_req = 0; chk_mask = 0; set_mask = 0;
    refresh();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: reset state
    check("R12", "busy after reset", busy, 0);
    check("R12", "px_we after reset", px_we, 0);
    check("R12", "fifo_pop after reset", fifo_pop, 0);
    check("R12", "done/aborted after reset", {done, aborted}, 0);

    // R1 R2 R4: basic 3x2 with junk in unused header bits
    do_rect("R1", 5, 7, 3, 2, 1, 0, 0, 0, 0);
    do_rect("R4", 100, 200, 7, 3, 2, 0, 0, 0, 2);
    // R6: odd pixel count, spare word must stay in the FIFO
    do_rect("R6", 9, 4, 3, 3, 3, 0, 0, 0, 1);
    // R5: wrap at both frame edges
    do_rect("R5", 1022, 511, 4, 2, 4, 0, 0, 0, 0);
    // R1: zero width means 1024, zero height means 512
    do_rect("R1", 0, 100, 0, 1, 5, 0, 0, 0, 0);
    do_rect("R1", 300, 0, 1, 0, 6, 0, 0, 0, 0);
    // R8 R9: mask handling
    do_rect("R8", 10, 20, 4, 3, 7, 0, 1, 1, 0);
    do_rect("R9", 30, 40, 5, 2, 8, 1, 0, 1, 0);
    do_rect("R8", 50, 60, 3, 4, 9, 1, 1, 1, 0);

    // R3 R11: FIFO fed a word at a time, second header while busy
    begin
      int p0, d0;
      cur_req = "R3";
      exp_push(12, 13, 5, 10, 10, 0, 0);
      p0 = n_pops; d0 = n_done;
      send_hdr(mk(12, 13), mk(5, 2));
      send_hdr(mk(700, 300), mk(8, 8));
      for (int i = 0; i < 5; i++) begin
        push_words(10, i, 1);
        repeat (4) @(negedge clk);
      end
      wait_end(200);
      check("R3", "words popped with trickle feed", n_pops - p0, 5);
      check("R11", "done pulses with extra header", n_done - d0, 1);
      check("R11", "pixels of first header", expq.size(), 0);
      repeat (5) @(negedge clk);
      check("R11", "busy after ignored header", busy, 0);
      fq.delete(); expq.delete(); refresh();
    end

    // R7: all-ones size word is ignored
    begin
      int p0, busy_seen;
      cur_req = "R7";
      push_words(11, 0, 2);
      p0 = n_pops; busy_seen = 0;
      send_hdr(mk(1, 1), 32'hFFFF_FFFF);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (busy) busy_seen++;
      end
      check("R7", "busy cycles after all-ones size", busy_seen, 0);
      check("R7", "words popped after all-ones size", n_pops - p0, 0);
      check("R7", "words left in FIFO", fq.size(), 2);
      fq.delete(); refresh();
    end

    // R10: abort while starved, after 4 of 10 words
    begin
      int p0, a0;
      cur_req = "R10";
      push_words(12, 0, 4);
      exp_push(0, 0, 5, 12, 8, 0, 0);
      p0 = n_pops; a0 = n_abort;
      send_hdr(mk(0, 0), mk(5, 4));
      repeat (20) @(negedge clk);
      check("R10", "busy while starved", busy, 1);
      abort_req = 1;
      @(negedge clk);
      abort_req = 0;
      wait_end(50);
      check("R10", "aborted pulses", n_abort - a0, 1);
      check("R10", "rows reached", last_rows, 1);
      check("R10", "cols reached", last_cols, 3);
      check("R10", "words popped", n_pops - p0, 4);
      check("R10", "pixels written", expq.size(), 0);
      push_words(12, 4, 3);
      repeat (10) @(negedge clk);
      check("R10", "pops after abort", n_pops - p0, 4);
      check("R10", "busy after abort", busy, 0);
      fq.delete(); expq.delete(); refresh();
    end

    // R10: abort in the middle of a flowing upload
    begin
      int p0, a0, dp;
      cur_req = "R10";
      push_words(13, 0, 8);
      exp_push(40, 50, 4, 13, 16, 0, 0);
      p0 = n_pops; a0 = n_abort;
      send_hdr(mk(40, 50), mk(4, 4));
      repeat (4) @(negedge clk);
      abort_req = 1;
      @(negedge clk);
      abort_req = 0;
      wait_end(100);
      dp = n_pops - p0;
      check("R10", "aborted pulses mid-stream", n_abort - a0, 1);
      check("R10", "stopped before the end", (dp < 8) ? 1 : 0, 1);
      check("R10", "rows from words consumed", last_rows, (2 * dp) / 4);
      check("R10", "cols from words consumed", last_cols, (2 * dp) % 4);
      check("R10", "pixels left unwritten", expq.size(), 16 - 2 * dp);
      fq.delete(); expq.delete(); refresh();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog run did not finish actual=%0d expected=<150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule